// File: doc/BRIEF.md
# Edge-Mode Input Capture Unit

This block samples one asynchronous input pin on the system clock and, whenever a selected edge condition is met, stores the present value of an externally supplied time-base count in a four-entry first-in first-out queue. A mode field chooses the edges that count. It can capture on rising edges, falling edges or both, or on every 4th or every 16th rising edge. Mode codes outside that set produce no captures.

A threshold field sets how many capture events must build up before a one-cycle interrupt pulse is raised. Software reads the oldest entry on `cap_data` and removes it with a one-cycle pop strobe. An empty flag reports when the queue holds nothing. A capture that arrives while the queue is full is dropped and sets a sticky overflow flag, which only a clear strobe resets. A width-select bit chooses whether the full 32-bit count is stored or only its low 16 bits, zero-extended.

Top module: `icap_unit`

## Requirements
- R1: With `mode` = 4'b0001, each rising edge of the synchronised pin stores one entry equal to the selected time-base value present when the edge is seen.
- R2: With `mode` = 4'b0010, only falling edges store entries; rising edges store nothing.
- R3: With `mode` = 4'b0011 or 4'b0000, both rising and falling edges store one entry each.
- R4: With `mode` = 4'b0100, one entry is stored on the 4th, 8th, 12th and later multiples of four rising edges, and on no other edge.
- R5: With `mode` = 4'b0101, one entry is stored on every 16th rising edge and on no other edge.
- R6: Mode codes 4'b0110, 4'b0111 and 4'b1xxx store no entries, raise no interrupt and never set overflow.
- R7: `irq` is high for exactly one cycle after the (`thresh`+1)-th capture event counted since reset, since the previous pulse or since the block was last disabled. The event count then restarts from zero. Dropped captures count as events.
- R8: The queue holds 4 entries and is read oldest first. `cap_data` shows the oldest entry. `cap_empty` is 1 exactly when the queue holds no entry. A pop strobe while the queue is non-empty removes the oldest entry.
- R9: A capture while 4 entries are held is discarded and sets `cap_ovf`. `cap_ovf` stays 1 until a cycle with `ovf_clr` = 1, after which it reads 0. Setting `thresh` above 4'b0011 without reads therefore overflows.
- R10: With `wide` = 1 the stored entry is the full 32-bit `timebase`. With `wide` = 0 it is `timebase[15:0]`, zero-extended to 32 bits.
- R11: While `enable` = 0 no edge is captured. The every-Nth edge counter restarts from zero whenever `enable` is 0 or `mode` changes value.
- R12: After reset `cap_empty` = 1, `cap_ovf` = 0 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable |
| mode | input | 4 | Edge condition select |
| thresh | input | 4 | Interrupt threshold: events needed, minus one |
| wide | input | 1 | 1 stores 32-bit count, 0 stores low 16 bits |
| pin_in | input | 1 | Asynchronous capture pin |
| timebase | input | 32 | Running time-base count |
| rd_pop | input | 1 | Remove the oldest queue entry |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| cap_data | output | 32 | Oldest queued capture |
| cap_empty | output | 1 | Queue holds no entry |
| cap_ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench runs a string of rising edges in every-4th mode, changes the mode away and back, and disables the unit partway through. It then checks that the next capture lands on a fresh count of four. A counter that was not cleared would capture too early. An overflow run uses a threshold above three with no reads, so the 5th and 6th captures must be dropped while the interrupt still follows the 6th event. A queue that overwrote old data or lost the event count would show up in the popped values or in the pulse count. Reserved mode codes and falling edges in rising-only mode are toggled to show that nothing is queued. Random mixes of edges, modes, thresholds, widths and reads are then compared entry by entry against a bench model.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int unsigned MODE_W = 4;
    localparam int unsigned DIV_W  = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RISE = 2'd1,
        SEL_FALL = 2'd2,
        SEL_ANY  = 2'd3
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e        sel;
        logic [DIV_W-1:0] last;   // edges per capture, minus one
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t r;
        r.sel  = SEL_NONE;
        r.last = '0;
        case (m)
            4'b0000: r.sel = SEL_ANY;
            4'b0001: r.sel = SEL_RISE;
            4'b0010: r.sel = SEL_FALL;
            4'b0011: r.sel = SEL_ANY;
            4'b0100: begin r.sel = SEL_RISE; r.last = DIV_W'(3);  end
            4'b0101: begin r.sel = SEL_RISE; r.last = DIV_W'(15); end
            default: r.sel = SEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_lvl,
    output logic pin_rise,
    output logic pin_fall
);
    // STAGES synchroniser flops followed by one history flop
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_lvl  = chain_q[STAGES-1];
    assign pin_rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign pin_fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/icap_qual.sv
module icap_qual
    import icap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              pin_rise,
    input  logic              pin_fall,
    output logic              cap_evt
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DIV_W-1:0]  cnt;
    } qual_t;

    qual_t     st_d, st_q;
    mode_dec_t dec;
    logic      hit;

    always_comb begin
        dec     = decode_mode(mode);
        st_d    = st_q;
        st_d.mode = mode;
        cap_evt = 1'b0;
        case (dec.sel)
            SEL_RISE: hit = pin_rise;
            SEL_FALL: hit = pin_fall;
            SEL_ANY:  hit = pin_rise | pin_fall;
            default:  hit = 1'b0;
        endcase
        if (!enable || (mode != st_q.mode)) begin
            st_d.cnt = '0;
        end else if (hit) begin
            if (st_q.cnt == dec.last) begin
                cap_evt  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              drop
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CNT_W'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        drop    = push & full;
        st_d    = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = bump(st_q.wr);
        end
        if (do_pop) st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head = st_q.mem[st_q.rd];
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned TH_W     = 4,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic [TH_W-1:0]   thresh,
    input  logic              wide,
    input  logic              pin_in,
    input  logic [TB_W-1:0]   timebase,
    input  logic              rd_pop,
    input  logic              ovf_clr,
    output logic [TB_W-1:0]   cap_data,
    output logic              cap_empty,
    output logic              cap_ovf,
    output logic              irq
);
    typedef struct packed {
        logic [TH_W-1:0] evt;
        logic            irq;
        logic            ovf;
    } ctl_t;

    ctl_t            st_d, st_q;
    logic            pin_lvl, pin_rise, pin_fall;
    logic            cap_evt, fifo_drop;
    logic [TB_W-1:0] cap_val;

    icap_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_lvl(pin_lvl), .pin_rise(pin_rise), .pin_fall(pin_fall)
    );

    icap_qual u_qual (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .pin_rise(pin_rise), .pin_fall(pin_fall), .cap_evt(cap_evt)
    );

    always_comb begin
        cap_val = wide ? timebase : {{(TB_W-NARROW_W){1'b0}}, timebase[NARROW_W-1:0]};
    end

    icap_fifo #(.DATA_W(TB_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cap_evt), .wdata(cap_val),
        .pop(rd_pop), .head(cap_data), .empty(cap_empty), .drop(fifo_drop)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!enable) begin
            st_d.evt = '0;
        end else if (cap_evt) begin
            if (st_q.evt == thresh) begin
                st_d.irq = 1'b1;
                st_d.evt = '0;
            end else begin
                st_d.evt = st_q.evt + 1'b1;
            end
        end
        if (fifo_drop)    st_d.ovf = 1'b1;
        else if (ovf_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq     = st_q.irq;
    assign cap_ovf = st_q.ovf;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [3:0] mode,
    input logic       cap_evt,
    input logic       pin_lvl,
    input logic       irq,
    input logic       cap_ovf,
    input logic       cap_empty,
    input logic       ovf_clr
);
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3] || (mode[2:1] == 2'b11)) |-> !cap_evt); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !cap_evt); // R11

    AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0010 && cap_evt) |-> !pin_lvl); // R2

    AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cap_evt)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ovf && !ovf_clr) |=> cap_ovf); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ovf) |-> $past(cap_evt && !cap_empty)); // R9
endmodule

bind icap_unit icap_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .cap_evt(cap_evt), .pin_lvl(pin_lvl), .irq(irq), .cap_ovf(cap_ovf),
    .cap_empty(cap_empty), .ovf_clr(ovf_clr)
);

// File: tb/icap_unit_test.sv
module icap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  mode = 4'b0001;
    logic [3:0]  thresh = 4'd0;
    logic        wide = 1'b1;
    logic        pin_in = 1'b0;
    logic [31:0] timebase = '0;
    logic        rd_pop = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] cap_data;
    logic        cap_empty, cap_ovf, irq;

    always #2.5 clk = ~clk;

    icap_unit uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .thresh(thresh),
        .wide(wide), .pin_in(pin_in), .timebase(timebase), .rd_pop(rd_pop),
        .ovf_clr(ovf_clr), .cap_data(cap_data), .cap_empty(cap_empty),
        .cap_ovf(cap_ovf), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, irq_seen = 0, irq_exp = 0;
    logic [31:0] mq [4];
    int mhead = 0, mcnt = 0, presc = 0, evt = 0;
    logic movf = 1'b0, mprev = 1'b0, done = 1'b0;

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int last_of(input logic [3:0] m);
        return (m == 4'b0100) ? 3 : (m == 4'b0101) ? 15 : 0;
    endfunction

    function automatic logic hit_of(input logic [3:0] m, input logic r, input logic f);
        case (m)
            4'b0000, 4'b0011: return r | f;
            4'b0001, 4'b0100, 4'b0101: return r;
            4'b0010: return f;
            default: return 1'b0;
        endcase
    endfunction

    task automatic pin_event(input logic v, input logic [31:0] tb, input string tag);
        logic r, f, cap;
        @(negedge clk);
        pin_in = v; timebase = tb;
        r = v & ~mprev; f = ~v & mprev; mprev = v; cap = 1'b0;
        if (enable && hit_of(mode, r, f)) begin
            if (presc == last_of(mode)) begin cap = 1'b1; presc = 0; end
            else presc++;
        end
        if (cap) begin
            if (mcnt == 4) movf = 1'b1;
            else begin
                mq[(mhead + mcnt) % 4] = wide ? tb : {16'h0, tb[15:0]};
                mcnt++;
            end
            if (evt == int'(thresh)) begin irq_exp++; evt = 0; end
            else evt = (evt + 1) % 16;
        end
        repeat (5) @(negedge clk);
        chk({tag, " irq count"}, irq_seen, irq_exp);
        chk({tag, " empty"}, cap_empty, (mcnt == 0));
        chk({tag, " overflow"}, cap_ovf, movf);
    endtask

    task automatic pop_chk(input string tag);
        @(negedge clk);
        chk({tag, " empty before pop"}, cap_empty, (mcnt == 0));
        if (mcnt != 0) begin
            chk({tag, " data"}, cap_data, mq[mhead]);
            rd_pop = 1'b1;
            mhead = (mhead + 1) % 4; mcnt--;
            @(negedge clk);
            rd_pop = 1'b0;
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        if (m != mode) presc = 0;
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_en(input logic e);
        @(negedge clk);
        enable = e;
        if (!e) begin presc = 0; evt = 0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_ovf();
        @(negedge clk); ovf_clr = 1'b1; movf = 1'b0;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk("R9 overflow cleared", cap_ovf, 1'b0);
    endtask

    task automatic rise_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pin_event(1'b1, 32'h1000_0000 + $urandom, tag);
            pin_event(1'b0, 32'h2000_0000 + $urandom, tag);
        end
    endtask

    task automatic drain(input string tag);
        while (mcnt != 0) pop_chk(tag);
        pop_chk(tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 empty after reset", cap_empty, 1'b1);
        chk("R12 overflow after reset", cap_ovf, 1'b0);
        chk("R12 irq after reset", irq_seen, 0);

        set_en(1'b1);
        // R1 rising edges
        set_mode(4'b0001);
        pin_event(1'b1, 32'hA1A1_0001, "R1");
        pin_event(1'b0, 32'hA1A1_0002, "R1");
        pin_event(1'b1, 32'hA1A1_0003, "R1");
        drain("R1");
        // R2 falling edges
        pin_event(1'b0, 32'hB2B2_0001, "R2");
        set_mode(4'b0010);
        pin_event(1'b1, 32'hB2B2_0002, "R2");
        pin_event(1'b0, 32'hB2B2_0003, "R2");
        pin_event(1'b1, 32'hB2B2_0004, "R2");
        pin_event(1'b0, 32'hB2B2_0005, "R2");
        drain("R2");
        // R3 both edges, two codes
        set_mode(4'b0011);
        rise_n(2, "R3");
        drain("R3");
        set_mode(4'b0000);
        rise_n(2, "R3");
        drain("R3");
        // R10 narrow width
        wide = 1'b0;
        set_mode(4'b0001);
        pin_event(1'b1, 32'hABCD_1234, "R10");
        pin_event(1'b0, 32'hFFFF_FFFF, "R10");
        drain("R10");
        wide = 1'b1;
        // R4 every 4th rising
        set_mode(4'b0100);
        rise_n(8, "R4");
        drain("R4");
        // R5 every 16th rising
        set_mode(4'b0101);
        rise_n(15, "R5");
        pop_chk("R5");
        rise_n(1, "R5");
        drain("R5");
        // R11 mode change and disable restart the prescaler
        set_mode(4'b0100);
        rise_n(2, "R11");
        set_mode(4'b0101);
        set_mode(4'b0100);
        rise_n(3, "R11");
        chk("R11 no early capture", cap_empty, 1'b1);
        rise_n(1, "R11");
        drain("R11");
        rise_n(2, "R11");
        set_en(1'b0);
        rise_n(3, "R11");
        set_en(1'b1);
        rise_n(3, "R11");
        chk("R11 no capture after re-enable", cap_empty, 1'b1);
        rise_n(1, "R11");
        drain("R11");
        // R6 reserved codes
        set_mode(4'b0110); rise_n(2, "R6");
        set_mode(4'b0111); rise_n(2, "R6");
        set_mode(4'b1000); rise_n(2, "R6");
        set_mode(4'b1111); rise_n(2, "R6");
        chk("R6 nothing queued", cap_empty, 1'b1);
        // R7 thresholds
        set_en(1'b0); set_en(1'b1);
        thresh = 4'd3;
        set_mode(4'b0001);
        rise_n(4, "R7");
        drain("R7");
        thresh = 4'd2;
        rise_n(3, "R7");
        drain("R7");
        // R9 overflow with threshold above queue depth
        thresh = 4'd5;
        rise_n(6, "R9");
        chk("R9 overflow set", cap_ovf, 1'b1);
        pop_chk("R8");
        chk("R9 overflow sticky", cap_ovf, 1'b1);
        drain("R8");
        clear_ovf();
        // random mix
        thresh = 4'd0;
        for (int k = 0; k < 400; k++) begin
            int c = $urandom_range(0, 19);
            if (c < 4) pop_chk("R8");
            else if (c == 4) set_mode(4'($urandom_range(0, 7)));
            else if (c == 5) thresh = 4'($urandom_range(0, 3));
            else if (c == 6) wide = 1'($urandom);
            else if (c == 7 && movf) clear_ovf();
            else pin_event(1'($urandom), $urandom, "R8");
        end
        drain("R8");
        summary();
    end
endmodule